// File: doc/BRIEF.md
# Edge-Selectable Interrupt Trigger

This block watches one signal picked from a small set of candidates and raises an interrupt request when that signal makes a programmed transition. The candidates are the external port clocks and an internal global trigger. A further code selects no signal, which silences the block. Detection of rising edges and detection of falling edges are enabled separately, so a source can interrupt on either edge, on both, or on neither.

The chosen signal is asynchronous to the block clock. It passes through a synchronizer chain, and edges are found by comparing the synchronized level with the level sampled one cycle earlier. A qualifying edge sets a sticky request flop. The active-low request pin stays asserted until a clear strobe arrives. Configuration is loaded through a single write strobe that updates the source code and both enables in the same cycle. When the source code changes, detection is blanked until the synchronizer holds only samples of the new source, so the switch itself never reads as an edge. The block has no data stream, so every pin is a plain control or status level.

Top module: `edge_irq_trigger`

## Requirements
- R1: The source code selects the watched signal as follows: codes 0 to N_EXT-1 pick `ext_clk_i[code]`, code N_EXT (6 by default) picks `glb_trig_i`, and code N_EXT+1 (7 by default) picks nothing. Signals that are not selected never affect the request.
- R2: With the rising enable set, a low-to-high change of the selected signal asserts the request.
- R3: With the falling enable set, a high-to-low change of the selected signal asserts the request.
- R4: With both enables set, either change asserts the request. With both enables clear, neither change asserts it.
- R5: While the "none" code is selected, no activity on any input asserts the request.
- R6: `irq_n_o` is active low and sticky. Once it is low, it stays low until a clear strobe, whatever the source does afterwards.
- R7: A clear strobe sampled at a clock edge with no qualifying edge pending drives `irq_n_o` high after that clock edge.
- R8: If a clear strobe and a newly detected qualifying edge fall on the same clock edge, the request is set (low).
- R9: A level change applied between two clock edges is reflected on `irq_n_o` after the third rising clock edge that follows it (SYNC_STAGES+1 edges): two synchronizer stages, then the request flop. After the second edge `irq_n_o` is still unchanged.
- R10: A change of source code never produces a request, even when the old and new sources sit at different levels. Detection resumes SYNC_STAGES+1 cycles after the write.
- R11: Reset leaves `irq_n_o` high, the source code at "none" and both enables clear.
- R12: A configuration write takes effect from the next cycle. A write that changes only the enables, and leaves the source code unchanged, does not blank detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads the source code and both enables |
| cfg_src_i | input | SEL_W (3) | Source code to load (see R1) |
| cfg_rise_i | input | 1 | Rising-edge enable to load |
| cfg_fall_i | input | 1 | Falling-edge enable to load |
| ext_clk_i | input | N_EXT (6) | External port clock lines, asynchronous |
| glb_trig_i | input | 1 | Internal global trigger, asynchronous |
| irq_clr_i | input | 1 | Clear strobe for the request |
| irq_n_o | output | 1 | Interrupt request, active low, sticky |

## Verification
The bench uses the default build: six external lines and a two-stage synchronizer. With these values the 3-bit source code has exactly eight meaningful values, so the sweep visits every code, every enable pair, every candidate line and both edge directions, and it checks the request latency at the exact cycle on each pass. Directed cases cover the timing corners: a switch between sources at opposite levels, clear and set landing on the same edge, an enable-only write with an edge right behind it, and a reset in the middle of an active request.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  // Flags for the two kinds of transition, produced by the edge stage.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_flags_t;

  // Fewest flops accepted in the synchronizer chain.
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Width of a source code that covers N_EXT lines, the global trigger and "none".
  function automatic int unsigned src_code_width(input int unsigned n_ext);
    return $clog2(n_ext + 2);
  endfunction

endpackage

// File: rtl/edge_irq_cfg.sv
module edge_irq_cfg #(
  parameter int unsigned N_EXT = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] src_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [SEL_W-1:0] src_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             src_load_o
);

  localparam logic [SEL_W-1:0] SRC_NONE = SEL_W'(N_EXT + 1);

  logic [SEL_W-1:0] src_q;
  logic             rise_q;
  logic             fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_NONE;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (we_i) begin
      src_q  <= src_i;
      rise_q <= rise_i;
      fall_q <= fall_i;
    end
  end

  // Only a change of source code restarts the blanking window.
  assign src_load_o = we_i && (src_i != src_q);
  assign src_o      = src_q;
  assign rise_o     = rise_q;
  assign fall_o     = fall_q;

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_EXT       = 6,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_i,
  input  logic             glb_i,
  input  logic [SEL_W-1:0] src_i,
  input  logic             src_none_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic             src_load_i,
  output edge_flags_t      flags_o,
  output logic             blanking_o
);

  localparam int unsigned CAND_N = 1 << SEL_W;
  localparam int unsigned BLK_W  = $clog2(SYNC_STAGES + 2);
  localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(SYNC_STAGES + 1);

  // Candidate vector padded to a power of two so any code indexes safely.
  logic [CAND_N-1:0] cand;

  for (genvar gi = 0; gi < CAND_N; gi++) begin : g_cand
    if (gi < N_EXT) begin : g_ext
      assign cand[gi] = ext_i[gi];
    end else if (gi == N_EXT) begin : g_glb
      assign cand[gi] = glb_i;
    end else begin : g_off
      assign cand[gi] = 1'b0;
    end
  end

  logic raw;
  assign raw = cand[src_i];

  // A single synchronizer chain behind the multiplexer.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      prev_q <= lvl;
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  // Blanking counter: covers the chain refill plus the reload of prev_q.
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
    end else if (src_load_i) begin
      blk_q <= BLK_LOAD;
    end else if (blk_q != '0) begin
      blk_q <= blk_q - 1'b1;
    end
  end

  logic armed;
  assign armed      = (blk_q == '0) && !src_none_i;
  assign blanking_o = (blk_q != '0);

  always_comb begin
    flags_o.rise = armed && rise_en_i &&  lvl && !prev_q;
    flags_o.fall = armed && fall_en_i && !lvl &&  prev_q;
  end

endmodule

// File: rtl/edge_irq_req.sv
module edge_irq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);

  logic req_q;

  // A new edge outranks a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (set_i) begin
      req_q <= 1'b1;
    end else if (clr_i) begin
      req_q <= 1'b0;
    end
  end

  assign irq_n_o = ~req_q;

endmodule

// File: rtl/edge_irq_trigger.sv
module edge_irq_trigger
  import edge_irq_pkg::*;
#(
  parameter  int unsigned N_EXT       = 6,
  parameter  int unsigned SYNC_STAGES = MIN_SYNC_STAGES,
  localparam int unsigned SEL_W       = src_code_width(N_EXT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_src_i,
  input  logic             cfg_rise_i,
  input  logic             cfg_fall_i,
  input  logic [N_EXT-1:0] ext_clk_i,
  input  logic             glb_trig_i,
  input  logic             irq_clr_i,
  output logic             irq_n_o
);

  localparam logic [SEL_W-1:0] SRC_NONE = SEL_W'(N_EXT + 1);

  logic [SEL_W-1:0] src_q;
  logic             rise_q;
  logic             fall_q;
  logic             src_load;
  logic             src_none;
  logic             blanking;
  logic             hit;
  edge_flags_t      flags;

  edge_irq_cfg #(
    .N_EXT (N_EXT),
    .SEL_W (SEL_W)
  ) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .src_i      (cfg_src_i),
    .rise_i     (cfg_rise_i),
    .fall_i     (cfg_fall_i),
    .src_o      (src_q),
    .rise_o     (rise_q),
    .fall_o     (fall_q),
    .src_load_o (src_load)
  );

  assign src_none = (src_q == SRC_NONE);

  edge_irq_detect #(
    .N_EXT       (N_EXT),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) det_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_clk_i),
    .glb_i      (glb_trig_i),
    .src_i      (src_q),
    .src_none_i (src_none),
    .rise_en_i  (rise_q),
    .fall_en_i  (fall_q),
    .src_load_i (src_load),
    .flags_o    (flags),
    .blanking_o (blanking)
  );

  assign hit = flags.rise | flags.fall;

  edge_irq_req req_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hit),
    .clr_i   (irq_clr_i),
    .irq_n_o (irq_n_o)
  );

endmodule

// File: rtl/edge_irq_trigger_chk.sv
module edge_irq_trigger_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_clr_i,
  input logic irq_n_o,
  input logic hit,
  input logic blanking,
  input logic src_none,
  input logic rise_q,
  input logic fall_q
);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> !irq_n_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !hit) |=> irq_n_o);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && !irq_clr_i) |=> !irq_n_o);

  p_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_n_o && !hit) |=> irq_n_o);

  p_none_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_none |-> !hit);

  p_switch_blank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blanking |-> !hit);

  p_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (rise_q || fall_q));

endmodule

bind edge_irq_trigger edge_irq_trigger_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_clr_i (irq_clr_i),
  .irq_n_o   (irq_n_o),
  .hit       (hit),
  .blanking  (blanking),
  .src_none  (src_none),
  .rise_q    (rise_q),
  .fall_q    (fall_q)
);

// File: tb/edge_irq_trigger_tb_top.sv
`timescale 1ns/1ps
module edge_irq_trigger_tb_top;

  localparam int N_EXT = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [2:0]       src = 3'd0;
  logic             c_rise = 1'b0;
  logic             c_fall = 1'b0;
  logic [N_EXT-1:0] ext = '0;
  logic             glb = 1'b0;
  logic             clr = 1'b0;
  logic             irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_trigger #(.N_EXT(N_EXT), .SYNC_STAGES(2)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_src_i  (src),
    .cfg_rise_i (c_rise),
    .cfg_fall_i (c_fall),
    .ext_clk_i  (ext),
    .glb_trig_i (glb),
    .irq_clr_i  (clr),
    .irq_n_o    (irq_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag, input string what);
    checks++;
    if (irq_n !== exp) begin
      fails++;
      $display("FAIL %s %s: irq_n=%0b expected %0b", tag, what, irq_n, exp);
    end
  endtask

  task automatic write_cfg(input int s, input logic r, input logic f);
    we = 1'b1; src = 3'(s); c_rise = r; c_fall = f;
    step(1);
    we = 1'b0;
  endtask

  task automatic set_line(input int l, input logic v);
    if (l < N_EXT) ext[l] = v;
    else glb = v;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic string sweep_tag(input int s, input int l, input bit r, input bit f, input bit up);
    if (s == N_EXT + 1) return "R5";
    if (s != l) return "R1";
    if (r && f) return "R4";
    if (!r && !f) return "R4";
    return up ? "R2" : "R3";
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check(1'b1, "R11", "request idle after reset");

    // R11: source is "none" after reset, so input activity is ignored
    ext = '1; glb = 1'b1;
    step(5);
    ext = '0; glb = 1'b0;
    step(5);
    check(1'b1, "R11", "reset select is none");

    // Sweep every code, enable pair, line and direction (R1..R5, R9, R7)
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 4; e++) begin
        bit r = e[0];
        bit f = e[1];
        ext = '0; glb = 1'b0;
        step(4);
        write_cfg(s, r, f);
        step(4);
        pulse_clr();
        for (int l = 0; l <= N_EXT; l++) begin
          bit exp_up = (s == l) && r;
          bit exp_dn = (s == l) && f;
          set_line(l, 1'b1);
          step(2);
          check(1'b1, "R9", "no change after two edges (rise)");
          step(1);
          check(!exp_up, sweep_tag(s, l, r, f, 1'b1), "rising change");
          pulse_clr();
          check(1'b1, "R7", "clear after rising case");
          set_line(l, 1'b0);
          step(2);
          check(1'b1, "R9", "no change after two edges (fall)");
          step(1);
          check(!exp_dn, sweep_tag(s, l, r, f, 1'b0), "falling change");
          pulse_clr();
          check(1'b1, "R7", "clear after falling case");
        end
      end
    end

    // R6: request stays low though the source goes back
    ext = '0; glb = 1'b0;
    write_cfg(0, 1'b1, 1'b0);
    step(4);
    pulse_clr();
    ext[0] = 1'b1;
    step(3);
    check(1'b0, "R6", "request set by rise");
    ext[0] = 1'b0;
    step(12);
    check(1'b0, "R6", "request sticky without clear");
    pulse_clr();
    check(1'b1, "R7", "sticky request cleared");

    // R8: clear lands on the same edge as a new detection
    ext[0] = 1'b1;
    step(2);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check(1'b0, "R8", "edge beats clear");
    pulse_clr();
    check(1'b1, "R7", "clear after collision");

    // R10: switch from a high source to a low one with falling enabled
    ext = '0; glb = 1'b0;
    ext[0] = 1'b1;
    write_cfg(0, 1'b0, 1'b1);
    step(4);
    write_cfg(N_EXT, 1'b0, 1'b1);
    step(1);
    pulse_clr();
    step(8);
    check(1'b1, "R10", "no false fall on select change");
    // and back from low global to high ext[0] with rising enabled
    write_cfg(0, 1'b1, 1'b0);
    step(8);
    check(1'b1, "R10", "no false rise on select change");
    // detection resumes after the window
    ext[0] = 1'b0;
    step(4);
    ext[0] = 1'b1;
    step(3);
    check(1'b0, "R10", "detection resumes after switch");
    pulse_clr();

    // R12: enable-only write, edge follows at once
    ext = '0;
    write_cfg(1, 1'b0, 1'b0);
    step(5);
    pulse_clr();
    write_cfg(1, 1'b1, 1'b0);
    ext[1] = 1'b1;
    step(3);
    check(1'b0, "R12", "enable-only write not blanked");
    pulse_clr();
    ext[1] = 1'b0;

    // R11: reset during an active request
    step(3);
    ext[1] = 1'b1;
    step(3);
    check(1'b0, "R11", "request set before reset");
    rst_n = 1'b0;
    step(1);
    check(1'b1, "R11", "reset drops request");
    rst_n = 1'b1;
    step(1);
    ext[1] = 1'b0;
    step(4);
    ext[1] = 1'b1;
    step(4);
    check(1'b1, "R11", "select and enables back to defaults");

    summary();
    $finish;
  end

endmodule